// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt request pulses from up to twelve peripherals and decides which one, if any, is offered to the processor. Each source has a one-byte control register holding a three-bit priority level and a pending flag. Software reaches these registers over a simple byte-wide bus with a combinational read path.

A pending source is offered only when three things hold. The global enable input must be high, and the source's level must be strictly above the processor's current priority level input. Because no processor level is below zero, a level of zero turns a source off. Among the sources that qualify, the highest level wins, and a tie goes to the source at the lower register address. The winner's index and level are presented combinationally. An acknowledge pulse clears that source's pending flag. Software may clear a pending flag but can never set one.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every source reads back 0x00 and `irq_valid` is 0.
- R2: In a control register, bits 2..0 hold the priority level and bit 3 holds the pending flag. Bits 7..4 ignore writes and always read as 0.
- R3: A bus write with bit 3 = 0 clears the addressed source's pending flag. A write with bit 3 = 1 leaves the flag as it was. Either way, bits 2..0 of the write replace the level.
- R4: A one-cycle pulse on `src_req[i]` sets pending flag i at the next clock edge. If a software clear or an acknowledge of the same source lands in that same cycle, the pulse wins.
- R5: Sources 0 through 11 sit at byte addresses 0x4D, 0x4E, 0x4F, 0x50, 0x51, 0x52, 0x56, 0x58, 0x59, 0x5A, 0x5B and 0x5C, in that order. Any other address reads 0x00, and writes to it change nothing.
- R6: A source is eligible only when its pending flag is 1, `glob_ie` is 1 and its level is strictly greater than `cpu_lvl`. A source at level 0 is therefore never offered.
- R7: Among eligible sources, the one with the highest level is presented. On a tie in level, the lowest source index (the lowest address) is presented.
- R8: `irq_valid`, `irq_src` and `irq_lvl` follow the register state and the inputs combinationally. While `irq_valid` is 1, `irq_ack` clears the presented source's pending flag at the next edge, after which the next winner is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 12 | Peripheral request pulses, one per source |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| glob_ie | input | 1 | Global maskable interrupt enable |
| cpu_lvl | input | 3 | Current processor priority level |
| irq_ack | input | 1 | Processor acknowledge of the presented request |
| irq_valid | output | 1 | A request is being presented |
| irq_src | output | 4 | Index of the presented source |
| irq_lvl | output | 3 | Level of the presented source |

## Verification
The assertions assume that `src_req` and `irq_ack` are sampled synchronously. They also assume that `irq_ack` is only meaningful while `irq_valid` is high, so an acknowledge with no request presented is harmless but not relied upon. The stimulus changes every input half a cycle away from the active edge and holds pulses for exactly one cycle. It raises `irq_ack` only after it has seen a presented request. The same-cycle collisions of R4 are driven on purpose, as one bus write and one pulse to the same source in a single cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int LVL_W   = 3;
    localparam int MAX_SRC = 12;

    // Byte address of the control register for each source index
    function automatic logic [ADDR_W-1:0] src_addr(input int idx);
        logic [ADDR_W-1:0] a;
        case (idx)
            0:  a = 8'h4D;
            1:  a = 8'h4E;
            2:  a = 8'h4F;
            3:  a = 8'h50;
            4:  a = 8'h51;
            5:  a = 8'h52;
            6:  a = 8'h56;
            7:  a = 8'h58;
            8:  a = 8'h59;
            9:  a = 8'h5A;
            10: a = 8'h5B;
            default: a = 8'h5C;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
    parameter int NUM_SRC = irq_pkg::MAX_SRC
) (
    input  logic [irq_pkg::ADDR_W-1:0] addr,
    output logic [NUM_SRC-1:0]         sel
);
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_dec
        assign sel[gi] = (addr == irq_pkg::src_addr(gi));
    end

    // R5: at most one register answers a given address
    always_comb begin
        a_r5_sel_onehot: assert ($onehot0(sel) || $isunknown(addr));
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
    parameter int NUM_SRC = irq_pkg::MAX_SRC,
    parameter int LVL_W   = irq_pkg::LVL_W,
    parameter int DATA_W  = irq_pkg::DATA_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [NUM_SRC-1:0]              sel,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [NUM_SRC-1:0]              src_req,
    input  logic [NUM_SRC-1:0]              ack_clr,
    output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o,
    output logic [NUM_SRC-1:0]              pend_o
);
    localparam int PEND_BIT = LVL_W;

    typedef struct packed {
        logic [NUM_SRC-1:0]            pend;
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_en && sel[i]) begin
                regs_d.lvl[i] = wdata[LVL_W-1:0];
                if (!wdata[PEND_BIT]) begin
                    regs_d.pend[i] = 1'b0;
                end
            end
            if (ack_clr[i]) begin
                regs_d.pend[i] = 1'b0;
            end
            if (src_req[i]) begin
                regs_d.pend[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign lvl_o  = regs_q.lvl;
    assign pend_o = regs_q.pend;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_chk
        // R4: a request pulse always leaves the flag set
        a_r4_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[gi] |=> pend_o[gi]);
        // R3: software can never raise a flag
        a_r3_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_req[gi] && !pend_o[gi]) |=> !pend_o[gi]);
        // R8: acknowledge without a pulse clears the flag
        a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_clr[gi] && !src_req[gi]) |=> !pend_o[gi]);
        // R5: the level changes only through its own address
        a_r5_lvl_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && sel[gi]) |=> $stable(lvl_o[gi]));
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC = irq_pkg::MAX_SRC,
    parameter int LVL_W   = irq_pkg::LVL_W,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0]              pend,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]   lvl,
    input  logic                            glob_ie,
    input  logic [LVL_W-1:0]                cpu_lvl,
    output logic                            valid,
    output logic [IDX_W-1:0]                win_idx,
    output logic [LVL_W-1:0]                win_lvl,
    output logic [NUM_SRC-1:0]              grant
);
    logic [NUM_SRC-1:0] elig;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            elig[i] = pend[i] && glob_ie && (lvl[i] > cpu_lvl);
        end
    end

    // Scan upward; a later source replaces the best only with a strictly higher level
    always_comb begin
        valid   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!valid || lvl[i] > win_lvl)) begin
                valid   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lvl[i];
            end
        end
        grant = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            grant[i] = valid && (win_idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int NUM_SRC = irq_pkg::MAX_SRC,
    parameter int LVL_W   = irq_pkg::LVL_W,
    parameter int DATA_W  = irq_pkg::DATA_W,
    parameter int ADDR_W  = irq_pkg::ADDR_W,
    parameter int IDX_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_req,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 glob_ie,
    input  logic [LVL_W-1:0]     cpu_lvl,
    input  logic                 irq_ack,
    output logic                 irq_valid,
    output logic [IDX_W-1:0]     irq_src,
    output logic [LVL_W-1:0]     irq_lvl
);
    localparam int PAD_W = DATA_W - LVL_W - 1;

    logic [NUM_SRC-1:0]            sel;
    logic [NUM_SRC-1:0]            grant;
    logic [NUM_SRC-1:0]            ack_clr;
    logic [NUM_SRC-1:0]            pend;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;

    irq_addr_dec #(.NUM_SRC(NUM_SRC)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign ack_clr = grant & {NUM_SRC{irq_ack}};

    irq_ctrl_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .src_req (src_req),
        .ack_clr (ack_clr),
        .lvl_o   (lvl),
        .pend_o  (pend)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
        .pend    (pend),
        .lvl     (lvl),
        .glob_ie (glob_ie),
        .cpu_lvl (cpu_lvl),
        .valid   (irq_valid),
        .win_idx (irq_src),
        .win_lvl (irq_lvl),
        .grant   (grant)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel[i]) begin
                bus_rdata = {{PAD_W{1'b0}}, pend[i], lvl[i]};
            end
        end
    end

    // R6: a presented request meets every gate
    a_r6_valid_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (glob_ie && irq_lvl > cpu_lvl && pend[irq_src] && lvl[irq_src] == irq_lvl));
    // R7: at most one source is granted
    a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R2: the unused upper bits never read back as 1
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:LVL_W+1] == '0);

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_prio
        // R7: no eligible source outranks the presented one
        a_r7_no_higher: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[gi] && glob_ie && lvl[gi] > cpu_lvl) |-> (irq_valid && irq_lvl >= lvl[gi]));
    end
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic         glob_ie = 1'b0;
    logic [2:0]   cpu_lvl = '0;
    logic         irq_ack = 1'b0;
    logic         irq_valid;
    logic [3:0]   irq_src;
    logic [2:0]   irq_lvl;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glob_ie(glob_ie), .cpu_lvl(cpu_lvl), .irq_ack(irq_ack),
        .irq_valid(irq_valid), .irq_src(irq_src), .irq_lvl(irq_lvl)
    );

    always #10 clk = ~clk;

    logic [7:0] amap [N] = '{8'h4D, 8'h4E, 8'h4F, 8'h50, 8'h51, 8'h52,
                             8'h56, 8'h58, 8'h59, 8'h5A, 8'h5B, 8'h5C};
    logic [2:0] m_lvl  [N];
    logic       m_pend [N];

    typedef struct {
        string      tag;
        bit         is_read;
        logic [7:0] exp_data;
        logic       exp_valid;
        logic [3:0] exp_src;
        logic [2:0] exp_lvl;
    } item_t;
    item_t q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic int model_winner();
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && glob_ie && m_lvl[i] > cpu_lvl) begin
                if (best < 0 || m_lvl[i] > m_lvl[best]) best = i;
            end
        end
        return best;
    endfunction

    // Monitor: pops expected items and compares with the live outputs
    initial begin
        item_t it;
        forever begin
            wait (q.size() > 0);
            it = q.pop_front();
            checks++;
            if (it.is_read) begin
                if (bus_rdata !== it.exp_data) begin
                    fails++;
                    $display("FAIL %s read addr %h: got %h expected %h", it.tag, bus_addr, bus_rdata, it.exp_data);
                end
            end else if (irq_valid !== it.exp_valid ||
                         (it.exp_valid && (irq_src !== it.exp_src || irq_lvl !== it.exp_lvl))) begin
                fails++;
                $display("FAIL %s irq: got v=%b s=%0d l=%0d expected v=%b s=%0d l=%0d",
                         it.tag, irq_valid, irq_src, irq_lvl, it.exp_valid, it.exp_src, it.exp_lvl);
            end
        end
    end

    task automatic step(input bit wr, input logic [7:0] addr, input logic [7:0] data,
                        input logic [N-1:0] req, input bit ack);
        int w;
        @(negedge clk);
        bus_wr = wr; bus_addr = addr; bus_wdata = data; src_req = req; irq_ack = ack;
        #1;
        w = model_winner();
        for (int i = 0; i < N; i++) begin
            if (wr && addr == amap[i]) begin
                m_lvl[i] = data[2:0];
                if (!data[3]) m_pend[i] = 1'b0;
            end
            if (ack && w == i) m_pend[i] = 1'b0;
            if (req[i]) m_pend[i] = 1'b1;
        end
        @(negedge clk);
        bus_wr = 1'b0; src_req = '0; irq_ack = 1'b0;
        #1;
    endtask

    task automatic chk_addr(input string tag, input logic [7:0] addr, input logic [7:0] exp);
        item_t it;
        bus_addr = addr;
        #1;
        it.tag = tag; it.is_read = 1; it.exp_data = exp;
        it.exp_valid = 0; it.exp_src = 0; it.exp_lvl = 0;
        q.push_back(it);
        #1;
    endtask

    task automatic chk_src(input string tag, input int i);
        chk_addr(tag, amap[i], {4'b0, m_pend[i], m_lvl[i]});
    endtask

    task automatic chk_irq(input string tag);
        item_t it;
        int w;
        #1;
        w = model_winner();
        it.tag = tag; it.is_read = 0; it.exp_data = 0;
        it.exp_valid = (w >= 0);
        it.exp_src = (w >= 0) ? 4'(w) : 4'd0;
        it.exp_lvl = (w >= 0) ? m_lvl[w] : 3'd0;
        q.push_back(it);
        #1;
    endtask

    function automatic logic [N-1:0] bit_of(input int i);
        return N'(1) << i;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_pend[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state
        for (int i = 0; i < N; i++) chk_addr("R1", amap[i], 8'h00);
        chk_irq("R1");

        // R2/R3: level written, bit3=1 does not set, upper bits dropped
        step(1, 8'h4D, 8'hFD, '0, 0);
        chk_src("R2", 0);
        chk_addr("R2", 8'h4D, 8'h05);

        // R4: pulse sets pending
        step(0, 8'h00, 8'h00, bit_of(0), 0);
        chk_addr("R4", 8'h4D, 8'h0D);

        // R6: global enable and strict level compare
        chk_irq("R6");
        glob_ie = 1; cpu_lvl = 0; chk_irq("R6");
        cpu_lvl = 5; chk_irq("R6");
        cpu_lvl = 4; chk_irq("R6");
        cpu_lvl = 0;

        // R7: tie at level 5 goes to source 0, then level 7 on source 7 wins
        step(1, 8'h50, 8'h05, bit_of(3), 0);
        chk_irq("R7");
        step(1, 8'h58, 8'h07, bit_of(7), 0);
        chk_irq("R7");

        // R6: level 0 source never presented
        step(1, 8'h5C, 8'h00, bit_of(11), 0);
        chk_src("R6", 11);

        // R5: unmapped addresses read 0 and writes change nothing
        step(1, 8'h53, 8'hFF, '0, 0);
        chk_addr("R5", 8'h53, 8'h00);
        chk_addr("R5", 8'h57, 8'h00);
        chk_addr("R5", 8'h4C, 8'h00);
        for (int i = 0; i < N; i++) chk_src("R5", i);

        // R8: acknowledge clears the presented source, next winner appears
        chk_irq("R8");
        step(0, 8'h00, 8'h00, '0, 1);
        chk_src("R8", 7);
        chk_irq("R8");

        // R3: writing 1 to bit 3 keeps pending, writing 0 clears it
        step(1, 8'h4D, 8'h0D, '0, 0);
        chk_src("R3", 0);
        step(1, 8'h4D, 8'h05, '0, 0);
        chk_src("R3", 0);
        chk_irq("R3");

        // R4: pulse beats a same-cycle software clear
        step(1, 8'h50, 8'h06, bit_of(3), 0);
        chk_addr("R4", 8'h50, 8'h0E);
        // R4: pulse beats a same-cycle acknowledge
        step(0, 8'h00, 8'h00, bit_of(3), 1);
        chk_addr("R4", 8'h50, 8'h0E);

        // R8: drain, leaving only the level-0 source pending
        step(0, 8'h00, 8'h00, '0, 1);
        chk_irq("R8");
        chk_src("R8", 3);

        // R7: equal levels on higher indices, lowest index wins
        step(1, 8'h5A, 8'h02, bit_of(9) | bit_of(10), 0);
        step(1, 8'h5B, 8'h02, '0, 0);
        chk_irq("R7");
        cpu_lvl = 2; chk_irq("R6");

        #1;
        finish_run();
    end
endmodule